// File: doc/BRIEF.md
# Internal Control Register Bank

This block holds the 64-bit internal control registers of a processor core: exception return state, interrupt priority and request masks, memory-management base and address-space registers, cache mode controls, a memory-control word and a parameterized set of scratch registers for privileged code. Each register is reached through a six-bit index, with one combinational read port and one write port that takes effect on the clock edge.

Each index has its own write behaviour. Some registers keep all 64 bits. Some keep only the bits of a fixed mask. Some are cleared by any write. Some cannot be written and report a fault. Some cannot be read and report a fault. Four command indices store nothing and instead send a one-cycle translation-buffer invalidate command out of the block. Reading the faulting-address register sends a strobe that releases the interrupt status lock. While the speculation input is high, writes, write faults and strobes are all suppressed. Reads still return data.

Top module: `ipr_bank`

## Requirements
- R1: After reset, index 0 (PAL base) reads the PAL_BASE_RST parameter, index 18 (memory control) reads 0x6, and every other readable index reads zero.
- R2: Indices 0, 18, 19 and the scratch indices 32 to 32+NUM_SCRATCH-1 store all 64 written bits. A combinational read returns the new value from the cycle after the write edge. A read of the index being written in the same cycle returns the old value.
- R3: These indices keep only the bits of their mask:
  - 2 and 3: 0xf
  - 4: 0x1f
  - 5: 0x18
  - 7: 0x7fff0
  - 8: 0xffffff0300
  - 9 and 10: 0xffffffffc0000000
  - 11: 0x1ffb
  - 12 and 13: 0x3f
  - 14: 0x7f0
  - 15: 0xfe00000000000000
- R4: Index 1 (restart address) stores the written value with bit 1 forced to zero.
- R5: Any write to index 16 or index 17 leaves that register at zero.
- R6: A write to index 20, 21, 22 or 23 raises wr_fault_o in the same cycle and changes nothing. These registers read as zero.
- R7: A read of index 6 or of indices 24 to 31 raises rd_fault_o and returns zero. Writes to these indices do not fault.
- R8: A write to index 28, 29, 30 or 31 raises tlb_cmd_o bit 0, 1, 2 or 3 respectively for exactly the one cycle after the write edge. tlb_cmd_o is zero otherwise.
- R9: unlock_o is high in the same cycle as a read of index 23 while speculation is low.
- R10: While spec_i is high, a write changes no register, raises no wr_fault_o and no tlb_cmd_o, and unlock_o stays low.
- R11: Indices from 32+NUM_SCRATCH to 63 fault on both read and write, and the read returns zero.
- R12: With rd_en_i low, rd_data_o is zero and rd_fault_o is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| spec_i | input | 1 | Speculation flag; suppresses writes and strobes |
| rd_en_i | input | 1 | Read request |
| rd_idx_i | input | 6 | Read register index |
| rd_data_o | output | 64 | Read data, zero on fault or no read |
| rd_fault_o | output | 1 | Read of an unreadable or undefined index |
| unlock_o | output | 1 | Interrupt status lock release strobe |
| wr_en_i | input | 1 | Write request |
| wr_idx_i | input | 6 | Write register index |
| wr_data_i | input | 64 | Write data |
| wr_fault_o | output | 1 | Write to an unwritable or undefined index |
| tlb_cmd_o | output | 4 | Invalidate commands: data-all, data-process, instruction-all, instruction-process |

## Verification
The hardest case to reach from the ports is a speculative write whose index and data would leave a visible mark if the write were not suppressed. This includes a command index, which would raise a strobe, a read-only index, which would raise a fault, and a same-cycle read of the written index. The stimulus first fills every register with all-ones patterns. It then runs long random sequences with speculation raised about one cycle in eight and indices drawn from every class. Each cycle is compared against a behavioural model of the bank, which also covers write-then-read of the same index in adjacent and equal cycles.

// File: rtl/ipr_pkg.sv
package ipr_pkg;

  localparam int unsigned XLEN      = 64;
  localparam int unsigned IDX_W     = 6;
  localparam int unsigned N_IDX     = 1 << IDX_W;
  localparam int unsigned N_STROBE  = 4;
  localparam int unsigned STROBE_SW = $clog2(N_STROBE);

  // Index map. IDX_STROBE0 is a multiple of N_STROBE so that the low
  // index bits select the command directly.
  localparam int unsigned IDX_PAL_BASE  = 0;
  localparam int unsigned IDX_RESTART   = 1;
  localparam int unsigned IDX_MEM_CTL   = 18;
  localparam int unsigned IDX_FAULT_VA  = 23;
  localparam int unsigned IDX_STROBE0   = 28;
  localparam int unsigned IDX_SCRATCH0  = 32;
  localparam logic [XLEN-1:0] MEM_CTL_RST = 64'h6;

  typedef enum logic [2:0] {
    KIND_NONE,    // undefined: faults both ways
    KIND_STORE,   // stores data through mask
    KIND_CLEAR,   // any write zeroes it
    KIND_WONLY,   // stores through mask, read faults
    KIND_RONLY,   // write faults
    KIND_STROBE   // write pulses a command, read faults
  } slot_kind_e;

  typedef struct packed {
    slot_kind_e      kind;
    logic [XLEN-1:0] mask;
  } slot_attr_t;

  function automatic slot_attr_t attr_of(input int unsigned idx,
                                         input int unsigned nscr);
    slot_attr_t a;
    a.kind = KIND_STORE;
    a.mask = '1;
    case (idx)
      0, 18, 19:  a.mask = '1;
      1:          a.mask = ~64'h2;
      2, 3:       a.mask = 64'hf;
      4:          a.mask = 64'h1f;
      5:          a.mask = 64'h18;
      6:          begin a.kind = KIND_WONLY; a.mask = 64'h18; end
      7:          a.mask = 64'h7fff0;
      8:          a.mask = 64'hff_ffff_0300;
      9, 10:      a.mask = 64'hffff_ffff_c000_0000;
      11:         a.mask = 64'h1ffb;
      12, 13:     a.mask = 64'h3f;
      14:         a.mask = 64'h7f0;
      15:         a.mask = 64'hfe00_0000_0000_0000;
      16, 17:     a.kind = KIND_CLEAR;
      20, 21, 22, 23: a.kind = KIND_RONLY;
      24, 25, 26, 27: a.kind = KIND_WONLY;
      28, 29, 30, 31: a.kind = KIND_STROBE;
      default: begin
        if (idx >= IDX_SCRATCH0 && idx < IDX_SCRATCH0 + nscr) a.kind = KIND_STORE;
        else                                                  a.kind = KIND_NONE;
      end
    endcase
    return a;
  endfunction

  function automatic logic can_read(input slot_kind_e k);
    return (k == KIND_STORE) || (k == KIND_CLEAR) || (k == KIND_RONLY);
  endfunction

  function automatic logic can_write(input slot_kind_e k);
    return (k == KIND_STORE) || (k == KIND_CLEAR) ||
           (k == KIND_WONLY) || (k == KIND_STROBE);
  endfunction

  function automatic logic [XLEN-1:0] reset_of(input int unsigned idx,
                                               input logic [XLEN-1:0] pal_rst);
    if (idx == IDX_PAL_BASE) return pal_rst;
    if (idx == IDX_MEM_CTL)  return MEM_CTL_RST;
    return '0;
  endfunction

endpackage

// File: rtl/ipr_decode.sv
module ipr_decode
  import ipr_pkg::*;
#(
  parameter int unsigned NUM_SCRATCH = 24
) (
  input  logic [IDX_W-1:0] rd_idx_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  output logic             rd_ok_o,
  output logic             wr_ok_o,
  output logic             wr_strobe_o
);

  slot_attr_t rd_attr, wr_attr;

  always_comb begin
    rd_attr     = attr_of(int'(rd_idx_i), NUM_SCRATCH);
    wr_attr     = attr_of(int'(wr_idx_i), NUM_SCRATCH);
    rd_ok_o     = can_read(rd_attr.kind);
    wr_ok_o     = can_write(wr_attr.kind);
    wr_strobe_o = (wr_attr.kind == KIND_STROBE);
  end

endmodule

// File: rtl/ipr_slot.sv
module ipr_slot
  import ipr_pkg::*;
#(
  parameter slot_kind_e      KIND = KIND_STORE,
  parameter logic [XLEN-1:0] MASK = '1,
  parameter logic [XLEN-1:0] RST  = '0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            we_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] q_o
);

  logic [XLEN-1:0] q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (we_i) begin
      if (KIND == KIND_CLEAR) q_d = '0;
      else                    q_d = wdata_i & MASK;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_q <= RST;
    else if (we_i) q_q <= q_d;
  end

  assign q_o = q_q;

  if (KIND == KIND_CLEAR) begin : g_clr_chk
    AST_CLEAR_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      we_i |=> (q_o == '0)); // R5
  end
  if (KIND == KIND_STORE && MASK != '1) begin : g_mask_chk
    AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (q_o & ~MASK) == '0); // R3
  end

endmodule

// File: rtl/ipr_strobe.sv
module ipr_strobe
  import ipr_pkg::*;
(
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 fire_i,
  input  logic [STROBE_SW-1:0] sel_i,
  output logic [N_STROBE-1:0]  cmd_o
);

  logic [N_STROBE-1:0] cmd_d, cmd_q;

  always_comb begin
    cmd_d = '0;
    for (int k = 0; k < int'(N_STROBE); k++) begin
      if (fire_i && (int'(sel_i) == k)) cmd_d[k] = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cmd_q <= '0;
    else         cmd_q <= cmd_d;
  end

  assign cmd_o = cmd_q;

  AST_CMD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(cmd_o)); // R8

endmodule

// File: rtl/ipr_bank.sv
module ipr_bank
  import ipr_pkg::*;
#(
  parameter int unsigned     NUM_SCRATCH  = 24,
  parameter logic [XLEN-1:0] PAL_BASE_RST = 64'h0000_0000_0001_4000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                spec_i,
  input  logic                rd_en_i,
  input  logic [IDX_W-1:0]    rd_idx_i,
  output logic [XLEN-1:0]     rd_data_o,
  output logic                rd_fault_o,
  output logic                unlock_o,
  input  logic                wr_en_i,
  input  logic [IDX_W-1:0]    wr_idx_i,
  input  logic [XLEN-1:0]     wr_data_i,
  output logic                wr_fault_o,
  output logic [N_STROBE-1:0] tlb_cmd_o
);

  logic            rd_ok, wr_ok, wr_strobe, wr_go;
  logic [XLEN-1:0] q [N_IDX];

  ipr_decode #(.NUM_SCRATCH(NUM_SCRATCH)) dec_i (
    .rd_idx_i    (rd_idx_i),
    .wr_idx_i    (wr_idx_i),
    .rd_ok_o     (rd_ok),
    .wr_ok_o     (wr_ok),
    .wr_strobe_o (wr_strobe)
  );

  assign wr_go = wr_en_i & ~spec_i;

  for (genvar g = 0; g < int'(N_IDX); g++) begin : g_slot
    localparam slot_attr_t SA = attr_of(g, NUM_SCRATCH);
    if (SA.kind == KIND_NONE || SA.kind == KIND_RONLY || SA.kind == KIND_STROBE) begin : g_zero
      assign q[g] = '0;
    end else begin : g_reg
      logic we;
      assign we = wr_go && (wr_idx_i == IDX_W'(g));
      ipr_slot #(
        .KIND (SA.kind),
        .MASK (SA.mask),
        .RST  (reset_of(g, PAL_BASE_RST))
      ) slot_i (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (we),
        .wdata_i (wr_data_i),
        .q_o     (q[g])
      );
      AST_SPEC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        spec_i |=> $stable(q[g])); // R10
    end
  end

  always_comb begin
    rd_fault_o = rd_en_i & ~rd_ok;
    rd_data_o  = (rd_en_i && rd_ok) ? q[rd_idx_i] : '0;
    unlock_o   = rd_en_i & ~spec_i & (rd_idx_i == IDX_W'(IDX_FAULT_VA));
    wr_fault_o = wr_go & ~wr_ok;
  end

  // The command base is aligned to N_STROBE, so the low index bits pick the command.
  ipr_strobe strobe_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (wr_go & wr_strobe),
    .sel_i  (wr_idx_i[STROBE_SW-1:0]),
    .cmd_o  (tlb_cmd_o)
  );

  AST_FAULT_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_fault_o |-> (rd_data_o == '0)); // R11
  AST_CMD_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|tlb_cmd_o) |-> $past(wr_en_i && !spec_i)); // R8
  AST_NO_SPEC_UNLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(spec_i) |-> !unlock_o); // R10

endmodule

// File: tb/ipr_bank_tb.sv
module ipr_bank_tb_top;

  localparam int          NS  = 24;
  localparam logic [63:0] PAL = 64'h0000_0000_0001_4000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic spec, rd_en, wr_en;
  logic [5:0] rd_idx, wr_idx;
  logic [63:0] wr_data, rd_data;
  logic rd_fault, unlock, wr_fault;
  logic [3:0] tlb_cmd;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [63:0] m [64];
  logic [3:0]  exp_cmd;

  always #4 clk = ~clk;

  ipr_bank #(.NUM_SCRATCH(NS), .PAL_BASE_RST(PAL)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .spec_i(spec),
    .rd_en_i(rd_en), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .rd_fault_o(rd_fault), .unlock_o(unlock),
    .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
    .wr_fault_o(wr_fault), .tlb_cmd_o(tlb_cmd)
  );

  function automatic bit readable(int i);
    return !(i == 6 || (i >= 24 && i <= 31) || i >= 32 + NS);
  endfunction

  function automatic bit writable(int i);
    return !((i >= 20 && i <= 23) || i >= 32 + NS);
  endfunction

  function automatic string tag_of(int i);
    if (i == 0 || i == 18 || i == 19 || (i >= 32 && i < 32 + NS)) return "R2";
    if (i == 1) return "R4";
    if (i == 16 || i == 17) return "R5";
    if (i >= 20 && i <= 23) return "R6";
    if (i == 6 || (i >= 24 && i <= 27)) return "R7";
    if (i >= 28 && i <= 31) return "R8";
    if (i >= 32 + NS) return "R11";
    return "R3";
  endfunction

  function automatic void model_write(int i, logic [63:0] v);
    case (i)
      0, 18, 19, 24, 25, 26, 27: m[i] = v;
      1:      m[i] = v & ~64'h2;
      2, 3:   m[i] = v & 64'hf;
      4:      m[i] = v & 64'h1f;
      5, 6:   m[i] = v & 64'h18;
      7:      m[i] = v & 64'h7fff0;
      8:      m[i] = v & 64'hff_ffff_0300;
      9, 10:  m[i] = v & 64'hffff_ffff_c000_0000;
      11:     m[i] = v & 64'h1ffb;
      12, 13: m[i] = v & 64'h3f;
      14:     m[i] = v & 64'h7f0;
      15:     m[i] = v & 64'hfe00_0000_0000_0000;
      default: if (i >= 32 && i < 32 + NS) m[i] = v; else m[i] = m[i];
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // One clock: drive, compare at mid-cycle, then advance the model.
  task automatic step(input logic re, input int ri, input logic we, input int wi,
                      input logic [63:0] wd, input logic sp, input string force_tag);
    string rt, wt;
    @(negedge clk);
    rd_en = re; rd_idx = ri[5:0]; wr_en = we; wr_idx = wi[5:0];
    wr_data = wd; spec = sp;
    #1;
    rt = (force_tag != "") ? force_tag : (re ? tag_of(ri) : "R12");
    wt = (force_tag != "") ? force_tag : (sp ? "R10" : tag_of(wi));
    chk(rt, "rd_data", rd_data, (re && readable(ri)) ? m[ri] : 64'h0);
    chk(rt, "rd_fault", 64'(rd_fault), 64'(re && !readable(ri)));
    chk((ri == 23) ? "R9" : rt, "unlock", 64'(unlock), 64'(re && !sp && ri == 23));
    chk(wt, "wr_fault", 64'(wr_fault), 64'(we && !sp && !writable(wi)));
    chk("R8", "tlb_cmd", 64'(tlb_cmd), 64'(exp_cmd));
    exp_cmd = 4'h0;
    if (we && !sp) begin
      model_write(wi, wd);
      if (wi >= 28 && wi <= 31) exp_cmd = 4'(1 << (wi - 28));
    end
  endtask

  initial begin
    for (int i = 0; i < 64; i++) m[i] = 64'h0;
    m[0] = PAL; m[18] = 64'h6;
    exp_cmd = 4'h0;
    spec = 0; rd_en = 0; wr_en = 0; rd_idx = 0; wr_idx = 0; wr_data = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset values of every index
    for (int i = 0; i < 64; i++) step(1, i, 0, 0, 64'h0, 0, readable(i) ? "R1" : "");
    // R12: idle read port
    step(0, 0, 0, 0, 64'h0, 0, "R12");
    // Fill with all ones then read back each index (R2 R3 R4 R5 R6 R7 R8 R11)
    for (int i = 0; i < 64; i++) step(0, 0, 1, i, 64'hffff_ffff_ffff_ffff, 0, "");
    for (int i = 0; i < 64; i++) step(1, i, 0, 0, 64'h0, 0, "");
    // R4 restart address with alternating pattern
    step(0, 0, 1, 1, 64'hdead_beef_cafe_f00f, 0, "R4");
    step(1, 1, 0, 0, 64'h0, 0, "R4");
    // R2 same-cycle read of written index returns old value, then new
    step(1, 40, 1, 40, 64'h1234_5678_9abc_def0, 0, "R2");
    step(1, 40, 0, 0, 64'h0, 0, "R2");
    // R10 speculative write to a store, a read-only and a command index
    step(0, 0, 1, 19, 64'h5555_aaaa_5555_aaaa, 1, "R10");
    step(1, 19, 1, 21, 64'h1, 1, "R10");
    step(1, 23, 1, 29, 64'h1, 1, "R10");
    step(0, 0, 0, 0, 64'h0, 0, "R10");
    // R9 unlock on faulting-address read
    step(1, 23, 0, 0, 64'h0, 0, "R9");
    // R8 back-to-back commands
    for (int i = 28; i < 32; i++) step(0, 0, 1, i, 64'hffff, 0, "R8");
    step(0, 0, 0, 0, 64'h0, 0, "R8");
    // R6 read-only write faults and leaves zero
    step(1, 22, 1, 22, 64'hffff, 0, "R6");
    step(1, 22, 0, 0, 64'h0, 0, "R6");

    // Random traffic across all classes
    for (int n = 0; n < 4000; n++) begin
      int ri, wi;
      logic [63:0] wd;
      ri = int'($urandom_range(63));
      wi = int'($urandom_range(63));
      if (($urandom_range(3)) == 0) ri = wi;
      wd = {$urandom(), $urandom()};
      step($urandom_range(1), ri, $urandom_range(1), wi, wd,
           ($urandom_range(7) == 0), "");
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule